// File: doc/BRIEF.md
# Lease-Timestamped L1 Data Cache

This block is a small direct-mapped L1 data cache for one core. Each line holds a tag, one data word and an expiry stamp; it holds no coherence state. A global time count, shared by every cache and brought in as an input, decides whether a stored line may still be read. A load hits only when the tag matches and the line's stamp is strictly later than the current global time. In every other case the load goes to the L2 bank as a fill request. The fill answer carries the word and a new stamp, and both are written into the line.

Stores always write through to L2 on a dedicated port and wait on no other cache. A store that finds a live copy also updates the local word but leaves the stamp alone. A store that misses does not allocate a line. Lines lapse on their own when time moves past their stamp, so the cache takes in no invalidation, recall or acknowledgement traffic. Only one miss may be in flight at a time. While it is in flight, `reqReady` is low.

Top module: `lease_l1_cache`

## Requirements
- R1: After reset every line reads as expired (stamp zero), so the first load to any address is a miss. After reset `reqReady` is 1 and `rspValid`, `fillReqValid` and `wtValid` are 0.
- R2: A load accepted while its tag matches and its stamp is greater than `globalTime` gives `rspValid` with the stored word in the next cycle, and no fill request.
- R3: The lease check is strict. At the cycle where `globalTime` equals the stamp the line is expired. One cycle earlier it still hits.
- R4: A load miss raises `fillReqValid` with the word address in the cycle after acceptance. When `fillRspValid` arrives, the cache returns `fillRspData` on `rspValid` in the next cycle and stores the word with `fillRspExpiry` as its stamp.
- R5: Within its lease a line returns its stored word even if L2 has changed. Once the lease has passed, a load with a matching tag fetches again and returns the new L2 word.
- R6: Every accepted store gives `wtValid` with its address and data in the next cycle, whether it hits or misses. A store miss allocates no line, so a later load to that address misses.
- R7: A store hit updates the local word, so the next load returns it, and leaves the line's stamp unchanged.
- R8: From a miss until the cycle after its fill response, `reqReady` stays 0, and only one fill request is issued.
- R9: Two addresses with the same low index bits evict each other: loading one replaces the other, which then misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| globalTime | input | TIME_W | Shared global time count |
| reqValid | input | 1 | Core request valid |
| reqReady | output | 1 | Cache can accept a request |
| reqWrite | input | 1 | 1 = store, 0 = load |
| reqAddr | input | ADDR_W | Word address |
| reqWdata | input | DATA_W | Store data |
| rspValid | output | 1 | Load data valid |
| rspData | output | DATA_W | Load data |
| fillReqValid | output | 1 | Fill request to L2 (one-cycle pulse) |
| fillReqAddr | output | ADDR_W | Address to fill |
| fillRspValid | input | 1 | Fill answer from L2 |
| fillRspData | input | DATA_W | Fill word |
| fillRspExpiry | input | TIME_W | Expiry stamp for the filled line |
| wtValid | output | 1 | Write-through valid (one-cycle pulse) |
| wtAddr | output | ADDR_W | Write-through address |
| wtData | output | DATA_W | Write-through data |

## Verification
The bench hits the lease boundary exactly: one load in the cycle before the stamp and one in the stamp's own cycle. A non-strict compare would return stale data at the second load. It changes the L2 image behind the cache to show that a live line serves its old word and that a lapsed line fetches the new one. A design that dropped the tag or the stamp check would show up here.

The bench checks that a store hit leaves the stamp alone by loading at the old stamp and expecting a miss. A design that refreshed the lease on store would hit there instead. The bench also checks that a store miss does not allocate and that lines with the same index evict each other. It watches `reqReady` while a fill is outstanding; a design that let a second request in would show `reqReady` high in that window.

// File: rtl/lease_cache_pkg.sv
package lease_cache_pkg;
  // strobes from control to datapath, valid in the accepting cycle
  typedef struct packed {
    logic loadHit;
    logic loadMiss;
    logic storeAcc;
    logic fillWrite;
  } ctrlStrobe_t;
endpackage

// File: rtl/lease_cache_ctrl.sv
module lease_cache_ctrl
  import lease_cache_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        reqWrite,
  input  logic        lineHit,
  input  logic        fillRspValid,
  output logic        reqReady,
  output ctrlStrobe_t strobe
);
  typedef enum logic {ST_IDLE, ST_WAIT} ctrlState_t;
  ctrlState_t state, stateNext;

  always_comb begin
    reqReady         = (state == ST_IDLE);
    strobe           = '0;
    stateNext        = state;
    if (state == ST_IDLE) begin
      if (reqValid && reqWrite) begin
        strobe.storeAcc = 1'b1;
      end else if (reqValid && lineHit) begin
        strobe.loadHit = 1'b1;
      end else if (reqValid) begin
        strobe.loadMiss = 1'b1;
        stateNext       = ST_WAIT;
      end
    end else if (fillRspValid) begin
      strobe.fillWrite = 1'b1;
      stateNext        = ST_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end
endmodule

// File: rtl/lease_cache_dp.sv
module lease_cache_dp
  import lease_cache_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 32,
  parameter int TIME_W  = 16,
  parameter int INDEX_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [TIME_W-1:0] globalTime,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] fillRspData,
  input  logic [TIME_W-1:0] fillRspExpiry,
  input  ctrlStrobe_t       strobe,
  output logic              lineHit,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData,
  output logic              fillReqValid,
  output logic [ADDR_W-1:0] fillReqAddr,
  output logic              wtValid,
  output logic [ADDR_W-1:0] wtAddr,
  output logic [DATA_W-1:0] wtData
);
  localparam int LINES = 1 << INDEX_W;
  localparam int TAG_W = ADDR_W - INDEX_W;

  logic [TAG_W-1:0]  tagArr  [LINES];
  logic [DATA_W-1:0] dataArr [LINES];
  logic [TIME_W-1:0] expArr  [LINES];

  logic [INDEX_W-1:0] reqIdx;
  logic [TAG_W-1:0]   reqTag;
  logic [ADDR_W-1:0]  pendAddr;
  logic [INDEX_W-1:0] pendIdx;

  assign reqIdx  = reqAddr[INDEX_W-1:0];
  assign reqTag  = reqAddr[ADDR_W-1:INDEX_W];
  assign pendIdx = pendAddr[INDEX_W-1:0];

  // lease check: live only while stamp is strictly later than global time
  assign lineHit = (tagArr[reqIdx] == reqTag) && (expArr[reqIdx] > globalTime);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < LINES; i++) begin
        tagArr[i]  <= '0;
        dataArr[i] <= '0;
        expArr[i]  <= '0;
      end
    end else if (strobe.fillWrite) begin
      tagArr[pendIdx]  <= pendAddr[ADDR_W-1:INDEX_W];
      dataArr[pendIdx] <= fillRspData;
      expArr[pendIdx]  <= fillRspExpiry;
    end else if (strobe.storeAcc && lineHit) begin
      dataArr[reqIdx] <= reqWdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendAddr     <= '0;
      rspValid     <= 1'b0;
      rspData      <= '0;
      fillReqValid <= 1'b0;
      fillReqAddr  <= '0;
      wtValid      <= 1'b0;
      wtAddr       <= '0;
      wtData       <= '0;
    end else begin
      rspValid     <= strobe.loadHit | strobe.fillWrite;
      fillReqValid <= strobe.loadMiss;
      wtValid      <= strobe.storeAcc;
      if (strobe.loadHit)   rspData <= dataArr[reqIdx];
      if (strobe.fillWrite) rspData <= fillRspData;
      if (strobe.loadMiss) begin
        pendAddr    <= reqAddr;
        fillReqAddr <= reqAddr;
      end
      if (strobe.storeAcc) begin
        wtAddr <= reqAddr;
        wtData <= reqWdata;
      end
    end
  end
endmodule

// File: rtl/lease_l1_cache.sv
module lease_l1_cache
  import lease_cache_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 32,
  parameter int TIME_W  = 16,
  parameter int INDEX_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [TIME_W-1:0] globalTime,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData,
  output logic              fillReqValid,
  output logic [ADDR_W-1:0] fillReqAddr,
  input  logic              fillRspValid,
  input  logic [DATA_W-1:0] fillRspData,
  input  logic [TIME_W-1:0] fillRspExpiry,
  output logic              wtValid,
  output logic [ADDR_W-1:0] wtAddr,
  output logic [DATA_W-1:0] wtData
);
  ctrlStrobe_t strobe;
  logic        lineHit;

  lease_cache_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .lineHit(lineHit), .fillRspValid(fillRspValid),
    .reqReady(reqReady), .strobe(strobe)
  );

  lease_cache_dp #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TIME_W(TIME_W), .INDEX_W(INDEX_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .globalTime(globalTime),
    .reqAddr(reqAddr), .reqWdata(reqWdata),
    .fillRspData(fillRspData), .fillRspExpiry(fillRspExpiry),
    .strobe(strobe), .lineHit(lineHit),
    .rspValid(rspValid), .rspData(rspData),
    .fillReqValid(fillReqValid), .fillReqAddr(fillReqAddr),
    .wtValid(wtValid), .wtAddr(wtAddr), .wtData(wtData)
  );
endmodule

// File: rtl/lease_cache_checker.sv
module lease_cache_checker #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqReady,
  input logic              reqWrite,
  input logic [ADDR_W-1:0] reqAddr,
  input logic [DATA_W-1:0] reqWdata,
  input logic              rspValid,
  input logic              fillReqValid,
  input logic              fillRspValid,
  input logic              wtValid,
  input logic [ADDR_W-1:0] wtAddr,
  input logic [DATA_W-1:0] wtData
);
  // R2 / R4: an accepted load is answered either from the line or by a fill request
  a_r2_load_answered: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && !reqWrite) |=> (rspValid ^ fillReqValid));

  // R4: the fill answer turns into load data one cycle later
  a_r4_fill_returns: assert property (@(posedge clk) disable iff (!rstN)
    (fillRspValid && !reqReady) |=> rspValid);

  // R6: every accepted store appears on the write-through port next cycle
  a_r6_write_through: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && reqWrite) |=>
      (wtValid && wtAddr == $past(reqAddr) && wtData == $past(reqWdata)));

  // R8: while a fill request is out, no new request is taken
  a_r8_blocked_on_miss: assert property (@(posedge clk) disable iff (!rstN)
    fillReqValid |-> !reqReady);

  // R8: a fill request is a single pulse
  a_r8_single_fill: assert property (@(posedge clk) disable iff (!rstN)
    fillReqValid |=> !fillReqValid);
endmodule

bind lease_l1_cache lease_cache_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
  .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata),
  .rspValid(rspValid), .fillReqValid(fillReqValid), .fillRspValid(fillRspValid),
  .wtValid(wtValid), .wtAddr(wtAddr), .wtData(wtData)
);

// File: tb/lease_l1_cache_tb.sv
module lease_l1_cache_tb;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 32;
  localparam int TIME_W = 16;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [TIME_W-1:0] globalTime = '0;
  logic              reqValid = 1'b0, reqWrite = 1'b0;
  logic              reqReady;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic [DATA_W-1:0] reqWdata = '0;
  logic              rspValid, fillReqValid, wtValid;
  logic [DATA_W-1:0] rspData, wtData;
  logic [ADDR_W-1:0] fillReqAddr, wtAddr;
  logic              fillRspValid = 1'b0;
  logic [DATA_W-1:0] fillRspData = '0;
  logic [TIME_W-1:0] fillRspExpiry = '0;

  always #5 clk = ~clk;
  always @(negedge clk) globalTime <= globalTime + 1'b1;

  lease_l1_cache u_dut (
    .clk(clk), .rstN(rstN), .globalTime(globalTime),
    .reqValid(reqValid), .reqReady(reqReady), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata),
    .rspValid(rspValid), .rspData(rspData),
    .fillReqValid(fillReqValid), .fillReqAddr(fillReqAddr),
    .fillRspValid(fillRspValid), .fillRspData(fillRspData),
    .fillRspExpiry(fillRspExpiry),
    .wtValid(wtValid), .wtAddr(wtAddr), .wtData(wtData)
  );

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  typedef struct {
    int          kind; // 0 load data, 1 fill request, 2 write-through
    logic [15:0] addr;
    logic [31:0] data;
    string       req;
  } expItem_t;
  expItem_t expQ[$];

  logic [31:0] l2Mem[int];
  logic [TIME_W-1:0] nextExpiry;

  function automatic logic [31:0] l2Read(logic [15:0] a);
    if (l2Mem.exists(int'(a))) return l2Mem[int'(a)];
    return 32'hA500_0000 | {16'h0, a};
  endfunction

  task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // monitor: pops expectations as outputs appear
  task automatic popCompare(int kind, logic [15:0] a, logic [31:0] d);
    expItem_t e;
    if (expQ.size() == 0) begin
      check(1'b0, "R8", "unexpected output kind", 32'(kind), 32'hFFFF_FFFF);
      return;
    end
    e = expQ.pop_front();
    check(e.kind == kind, e.req, "output kind", 32'(kind), 32'(e.kind));
    if (e.kind == kind) begin
      if (kind == 0) check(d == e.data, e.req, "load data", d, e.data);
      if (kind == 1) check(a == e.addr, e.req, "fill addr", {16'h0, a}, {16'h0, e.addr});
      if (kind == 2) begin
        check(a == e.addr, e.req, "write-through addr", {16'h0, a}, {16'h0, e.addr});
        check(d == e.data, e.req, "write-through data", d, e.data);
      end
    end
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (rstN) begin
        if (fillReqValid) popCompare(1, fillReqAddr, '0);
        if (rspValid)     popCompare(0, '0, rspData);
        if (wtValid)      popCompare(2, wtAddr, wtData);
      end
    end
  end

  // L2 model: answers fill requests after two cycles, checking R8 meanwhile
  initial begin
    logic [15:0] a;
    forever begin
      @(negedge clk);
      if (rstN && fillReqValid) begin
        a = fillReqAddr;
        for (int k = 0; k < 2; k++) begin
          check(reqReady == 1'b0, "R8", "ready low during miss", {31'h0, reqReady}, 32'h0);
          @(negedge clk);
        end
        check(reqReady == 1'b0, "R8", "ready low before fill", {31'h0, reqReady}, 32'h0);
        fillRspValid  = 1'b1;
        fillRspData   = l2Read(a);
        fillRspExpiry = nextExpiry;
        @(negedge clk);
        fillRspValid = 1'b0;
      end
    end
  end

  task automatic issue(bit wr, logic [15:0] a, logic [31:0] d);
    while (!reqReady) begin @(negedge clk); #1; end
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqWdata = d;
    @(negedge clk); #1;
    reqValid = 1'b0; reqWrite = 1'b0;
  endtask

  task automatic load(logic [15:0] a, bit expHit, logic [31:0] expData, string req);
    if (!expHit) expQ.push_back('{1, a, '0, req});
    expQ.push_back('{0, a, expData, req});
    issue(1'b0, a, '0);
  endtask

  task automatic store(logic [15:0] a, logic [31:0] d, string req);
    expQ.push_back('{2, a, d, req});
    l2Mem[int'(a)] = d;
    issue(1'b1, a, d);
  endtask

  task automatic settle();
    for (int k = 0; k < 40 && (expQ.size() != 0 || !reqReady); k++) begin
      @(negedge clk); #1;
    end
  endtask

  task automatic waitTime(logic [TIME_W-1:0] t);
    while (globalTime != t) begin @(negedge clk); #1; end
  endtask

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  localparam logic [15:0] A_ADDR = 16'h0013;
  localparam logic [15:0] C_ADDR = 16'h0123; // same index as A, other tag
  localparam logic [15:0] B_ADDR = 16'h0045;

  initial begin
    logic [31:0] oldA, newA;
    logic [TIME_W-1:0] expA;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk); #1;
    // R1: reset state
    check(reqReady == 1'b1, "R1", "ready after reset", {31'h0, reqReady}, 32'h1);
    check(rspValid == 1'b0, "R1", "rspValid after reset", {31'h0, rspValid}, 32'h0);
    check(fillReqValid == 1'b0, "R1", "fillReqValid after reset", {31'h0, fillReqValid}, 32'h0);
    check(wtValid == 1'b0, "R1", "wtValid after reset", {31'h0, wtValid}, 32'h0);

    // R1 / R4: first load misses and is filled
    oldA = l2Read(A_ADDR);
    nextExpiry = globalTime + 16'd40; expA = nextExpiry;
    load(A_ADDR, 1'b0, oldA, "R4"); settle();
    // R2: hit with stored word
    load(A_ADDR, 1'b1, oldA, "R2"); settle();

    // R5: L2 changes behind the cache; live line still returns old word
    newA = 32'h1234_5678;
    l2Mem[int'(A_ADDR)] = newA;
    load(A_ADDR, 1'b1, oldA, "R5"); settle();
    // R3: one cycle before the stamp still hits
    waitTime(expA - 1'b1);
    load(A_ADDR, 1'b1, oldA, "R3"); settle();
    // R3 / R5: at the stamp the line is expired and refetched
    nextExpiry = expA + 16'd50; expA = nextExpiry;
    waitTime(expA - 16'd50);
    load(A_ADDR, 1'b0, newA, "R3_R5"); settle();

    // R7: store hit updates word, stamp unchanged
    store(A_ADDR, 32'hDEAD_0001, "R6"); settle();
    load(A_ADDR, 1'b1, 32'hDEAD_0001, "R7"); settle();
    nextExpiry = expA + 16'd60;
    waitTime(expA);
    load(A_ADDR, 1'b0, 32'hDEAD_0001, "R7"); settle();
    expA = nextExpiry;

    // R6: store miss, no allocate
    store(B_ADDR, 32'hBEEF_0002, "R6"); settle();
    nextExpiry = globalTime + 16'd200;
    load(B_ADDR, 1'b0, 32'hBEEF_0002, "R6"); settle();

    // R9: conflicting index evicts
    load(C_ADDR, 1'b0, l2Read(C_ADDR), "R9"); settle();
    load(A_ADDR, 1'b0, 32'hDEAD_0001, "R9"); settle();
    load(C_ADDR, 1'b0, l2Read(C_ADDR), "R9"); settle();

    // R2: back-to-back hits across lines
    load(B_ADDR, 1'b1, 32'hBEEF_0002, "R2");
    load(C_ADDR, 1'b1, l2Read(C_ADDR), "R2");
    load(B_ADDR, 1'b1, 32'hBEEF_0002, "R2");
    settle();

    check(expQ.size() == 0, "R2", "all expected outputs seen", 32'(expQ.size()), 32'h0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule